// File: doc/BRIEF.md
# Tagged Memory Port Request Engine

This block connects a simple user command channel to one port of a memory controller that has separate request and response channels. A user command is either a load or a store with an address, a 2-bit access size and, for a store, 64 bits of write data. The engine turns each accepted command into a one-cycle load or store strobe toward the memory port. It respects two independent stall inputs: one throttles reads and one throttles writes.

Loads are tracked with a pool of read tags. Each issued load takes the lowest-numbered free tag and sends it in the low bits of the shared 64-bit request bus. The memory echoes the tag on its 32-bit response tag bus. The engine uses the echoed tag to find the user identifier that was stored against it, so responses that arrive out of order still reach the user with the correct identifier. Returned data and identifiers wait in a small response buffer. The engine raises a stall toward the memory while that buffer is full.

A flush command drains all outstanding loads and then raises a one-cycle flush request. When the memory reports flush-complete, the engine reports the flush as done. No new commands are accepted from the moment the flush command is taken until the flush is done.

Top module: `tagReqEngine`

## Requirements
- R1: A load is issued only in a cycle where `memRdStall` is low, and a store only in a cycle where `memWrStall` is low. Each stall input blocks only its own kind of request.
- R2: An accepted command (`cmdValid` and `cmdReady` high) produces, in the same cycle, `memLd` (when `cmdIsStore`=0) or `memSt` (when `cmdIsStore`=1), with `memAddr` equal to `cmdAddr`. The two strobes are never high together, and at most one request is issued per clock.
- R3: `memSize` equals `cmdSize` for loads and stores alike: 0 = byte, 1 = word, 2 = double-word, 3 = quad-word.
- R4: During a store, `memWrdTag` equals `cmdData`.
- R5: During a load, `memWrdTag[31:0]` holds the read tag and `memWrdTag[63:32]` is zero. The tag is the lowest-numbered tag that is not outstanding.
- R6: At most NTAGS loads are outstanding at once. While every tag is in use, `cmdReady` is low for loads but stays high for stores. A tag becomes free in the cycle after a response that carries it is pushed, including a response that is dropped.
- R7: Every response pushed while `memRspStall` is low is delivered on `usrRspData`/`usrRspId`. Responses leave in the order they arrived. Each carries the push-cycle data and the `cmdId` of the load that took the returned tag. A delivery happens on a clock edge where `usrRspValid` and `usrRspReady` are both high.
- R8: `memRspStall` is high exactly while the response buffer holds RSP_DEPTH entries. A push in such a cycle is dropped and sets `protoErr`, which stays high until reset.
- R9: A `flushReq` pulse accepted while idle blocks new commands (`cmdReady` low) from that cycle on. `memFlush` rises for exactly one cycle, and only after no load is outstanding. `flushDone` is high in the cycle `memFlushDone` is seen after that pulse. From the next cycle, commands are accepted again.
- R10: After reset: `memLd`, `memSt`, `memFlush`, `flushDone`, `usrRspValid`, `memRspStall` and `protoErr` are low, and a load is ready when `memRdStall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | User command present |
| cmdIsStore | input | 1 | 1 = store, 0 = load |
| cmdSize | input | 2 | Access size code |
| cmdAddr | input | ADDR_W | Target address |
| cmdData | input | 64 | Store data |
| cmdId | input | ID_W | User identifier returned with load data |
| cmdReady | output | 1 | Command accepted this cycle when valid |
| flushReq | input | 1 | Start a flush (pulse) |
| flushDone | output | 1 | Flush completed |
| usrRspValid | output | 1 | Response buffer not empty |
| usrRspReady | input | 1 | User takes the head response |
| usrRspData | output | 64 | Head response data |
| usrRspId | output | ID_W | Head response identifier |
| protoErr | output | 1 | Sticky: response pushed while stalled |
| memLd | output | 1 | Load strobe |
| memSt | output | 1 | Store strobe |
| memSize | output | 2 | Access size |
| memAddr | output | ADDR_W | Request address |
| memWrdTag | output | 64 | Write data or read tag |
| memFlush | output | 1 | Flush request |
| memRdStall | input | 1 | Read requests stalled |
| memWrStall | input | 1 | Write requests stalled |
| memRspPush | input | 1 | Response valid |
| memRspStall | output | 1 | Response throttle |
| memRspData | input | 64 | Response data |
| memRspTag | input | 32 | Echoed read tag |
| memFlushDone | input | 1 | Flush complete |

## Verification
The bench builds the engine with NTAGS=4, ID_W=8 and RSP_DEPTH=4. The small tag pool can be exhausted after only four loads, which exercises blocked loads, reuse of the lowest free tag, and fully reversed return orders. With four buffer entries, filling the buffer to raise the response stall and then forcing a dropped push takes only a few cycles.

// File: rtl/tre_pkg.sv
package tre_pkg;
  typedef struct packed {
    logic issueLd;
    logic issueSt;
    logic rspWrite;
    logic rspPop;
  } ctlStrobe_t;

  typedef enum logic [1:0] {FL_IDLE, FL_DRAIN, FL_REQ, FL_WAIT} flushState_t;
endpackage

// File: rtl/tre_ctrl.sv
module tre_ctrl
  import tre_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdIsStore,
  input  logic       flushReq,
  input  logic       memRdStall,
  input  logic       memWrStall,
  input  logic       memRspPush,
  input  logic       memFlushDone,
  input  logic       usrRspReady,
  input  logic       tagFree,
  input  logic       anyBusy,
  input  logic       fifoFull,
  input  logic       fifoEmpty,
  output ctlStrobe_t strobe,
  output logic       cmdReady,
  output logic       memFlush,
  output logic       flushDone,
  output logic       protoErr,
  output logic       memRspStall
);
  flushState_t flState, flNext;
  logic blocked, ldOk, stOk;

  // Command gating
  always_comb begin
    blocked  = (flState != FL_IDLE) || flushReq;
    ldOk     = !memRdStall && tagFree;
    stOk     = !memWrStall;
    cmdReady = !blocked && (cmdIsStore ? stOk : ldOk);
    strobe.issueLd  = cmdValid && cmdReady && !cmdIsStore;
    strobe.issueSt  = cmdValid && cmdReady && cmdIsStore;
    strobe.rspWrite = memRspPush && !fifoFull;
    strobe.rspPop   = !fifoEmpty && usrRspReady;
    memRspStall     = fifoFull;
  end

  // Flush sequencing
  always_comb begin
    flNext = flState;
    unique case (flState)
      FL_IDLE:  if (flushReq) flNext = FL_DRAIN;
      FL_DRAIN: if (!anyBusy) flNext = FL_REQ;
      FL_REQ:   flNext = FL_WAIT;
      FL_WAIT:  if (memFlushDone) flNext = FL_IDLE;
      default:  flNext = FL_IDLE;
    endcase
  end

  assign memFlush  = (flState == FL_REQ);
  assign flushDone = (flState == FL_WAIT) && memFlushDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flState  <= FL_IDLE;
      protoErr <= 1'b0;
    end else begin
      flState <= flNext;
      if (memRspPush && fifoFull) protoErr <= 1'b1;
    end
  end

  AST_FLUSH_DRAINED: assert property (@(posedge clk) disable iff (!rstN)
    memFlush |-> !anyBusy); // R9
  AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    memFlush |=> !memFlush); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr); // R8
endmodule

// File: rtl/tre_dpath.sv
module tre_dpath
  import tre_pkg::*;
#(
  parameter int ID_W      = 8,
  parameter int NTAGS     = 16,
  parameter int RSP_DEPTH = 4,
  parameter int DATA_W    = 64,
  parameter int RTAG_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ID_W-1:0]   cmdId,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              memRspPush,
  input  logic [RTAG_W-1:0] memRspTag,
  input  logic [DATA_W-1:0] memRspData,
  output logic [DATA_W-1:0] memWrdTag,
  output logic              tagFree,
  output logic              anyBusy,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic [DATA_W-1:0] usrRspData,
  output logic [ID_W-1:0]   usrRspId
);
  localparam int TAG_W = (NTAGS > 1) ? $clog2(NTAGS) : 1;
  localparam int PTR_W = (RSP_DEPTH > 1) ? $clog2(RSP_DEPTH) : 1;
  localparam int CNT_W = $clog2(RSP_DEPTH + 1);
  localparam int HALF  = DATA_W / 2;

  logic [NTAGS-1:0] busy;
  logic [ID_W-1:0]  idTable [NTAGS];
  logic [TAG_W-1:0] allocTag, rspTag;

  logic [DATA_W-1:0] fifoData [RSP_DEPTH];
  logic [ID_W-1:0]   fifoId   [RSP_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;

  // Lowest free tag
  always_comb begin
    allocTag = '0;
    for (int i = NTAGS - 1; i >= 0; i--) begin
      if (!busy[i]) allocTag = TAG_W'(i);
    end
  end

  assign tagFree = ~&busy;
  assign anyBusy = |busy;
  assign rspTag  = memRspTag[TAG_W-1:0];

  // Shared request bus: write data or zero-extended read tag
  always_comb begin
    if (strobe.issueSt) memWrdTag = cmdData;
    else memWrdTag = {{(HALF){1'b0}}, {(HALF-TAG_W){1'b0}}, allocTag};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= '0;
    end else begin
      for (int t = 0; t < NTAGS; t++) begin
        if (strobe.issueLd && allocTag == TAG_W'(t)) busy[t] <= 1'b1;
        else if (memRspPush && rspTag == TAG_W'(t)) busy[t] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.issueLd) idTable[allocTag] <= cmdId;
  end

  // Response buffer
  assign fifoFull   = (count == CNT_W'(RSP_DEPTH));
  assign fifoEmpty  = (count == '0);
  assign usrRspData = fifoData[rdPtr];
  assign usrRspId   = fifoId[rdPtr];

  always_ff @(posedge clk) begin
    if (strobe.rspWrite) begin
      fifoData[wrPtr] <= memRspData;
      fifoId[wrPtr]   <= idTable[rspTag];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.rspWrite)
        wrPtr <= (wrPtr == PTR_W'(RSP_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (strobe.rspPop)
        rdPtr <= (rdPtr == PTR_W'(RSP_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({strobe.rspWrite, strobe.rspPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueLd |-> !busy[allocTag]); // R6
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(RSP_DEPTH)); // R8
  AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull && !strobe.rspPop |=> fifoFull); // R8
endmodule

// File: rtl/tagReqEngine.sv
module tagReqEngine
  import tre_pkg::*;
#(
  parameter int ID_W      = 8,
  parameter int NTAGS     = 16,
  parameter int RSP_DEPTH = 4,
  parameter int ADDR_W    = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdIsStore,
  input  logic [1:0]        cmdSize,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [63:0]       cmdData,
  input  logic [ID_W-1:0]   cmdId,
  output logic              cmdReady,
  input  logic              flushReq,
  output logic              flushDone,
  output logic              usrRspValid,
  input  logic              usrRspReady,
  output logic [63:0]       usrRspData,
  output logic [ID_W-1:0]   usrRspId,
  output logic              protoErr,
  output logic              memLd,
  output logic              memSt,
  output logic [1:0]        memSize,
  output logic [ADDR_W-1:0] memAddr,
  output logic [63:0]       memWrdTag,
  output logic              memFlush,
  input  logic              memRdStall,
  input  logic              memWrStall,
  input  logic              memRspPush,
  output logic              memRspStall,
  input  logic [63:0]       memRspData,
  input  logic [31:0]       memRspTag,
  input  logic              memFlushDone
);
  ctlStrobe_t strobe;
  logic tagFree, anyBusy, fifoFull, fifoEmpty;

  tre_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIsStore(cmdIsStore),
    .flushReq(flushReq), .memRdStall(memRdStall), .memWrStall(memWrStall),
    .memRspPush(memRspPush), .memFlushDone(memFlushDone),
    .usrRspReady(usrRspReady), .tagFree(tagFree), .anyBusy(anyBusy),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .strobe(strobe),
    .cmdReady(cmdReady), .memFlush(memFlush), .flushDone(flushDone),
    .protoErr(protoErr), .memRspStall(memRspStall)
  );

  tre_dpath #(
    .ID_W(ID_W), .NTAGS(NTAGS), .RSP_DEPTH(RSP_DEPTH), .DATA_W(64), .RTAG_W(32)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdId(cmdId), .cmdData(cmdData),
    .memRspPush(memRspPush), .memRspTag(memRspTag), .memRspData(memRspData),
    .memWrdTag(memWrdTag), .tagFree(tagFree), .anyBusy(anyBusy),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .usrRspData(usrRspData), .usrRspId(usrRspId)
  );

  assign memLd       = strobe.issueLd;
  assign memSt       = strobe.issueSt;
  assign memSize     = cmdSize;
  assign memAddr     = cmdAddr;
  assign usrRspValid = !fifoEmpty;

  AST_LD_RD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    memLd |-> !memRdStall); // R1
  AST_ST_WR_STALL: assert property (@(posedge clk) disable iff (!rstN)
    memSt |-> !memWrStall); // R1
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !(memLd && memSt)); // R2
  AST_QUIET_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    memFlush |-> !(memLd || memSt)); // R9
endmodule

// File: tb/test_tagReqEngine.sv
module test_tagReqEngine;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 8;
  localparam int NT   = 4;
  localparam int DEP  = 4;

  logic clk = 0, rstN = 0;
  logic cmdValid = 0, cmdIsStore = 0, flushReq = 0, usrRspReady = 1;
  logic [1:0] cmdSize = 0;
  logic [47:0] cmdAddr = 0;
  logic [63:0] cmdData = 0, memRspData = 0;
  logic [ID_W-1:0] cmdId = 0;
  logic memRdStall = 0, memWrStall = 0, memRspPush = 0, memFlushDone = 0;
  logic [31:0] memRspTag = 0;
  logic cmdReady, flushDone, usrRspValid, protoErr, memLd, memSt, memFlush, memRspStall;
  logic [63:0] usrRspData, memWrdTag;
  logic [ID_W-1:0] usrRspId;
  logic [1:0] memSize;
  logic [47:0] memAddr;

  int checks = 0, errors = 0, delivered = 0, pushedOk = 0;
  logic [NT-1:0] bBusy = '0;
  logic [ID_W-1:0] bId [NT];
  logic [ID_W+63:0] expQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tagReqEngine #(.ID_W(ID_W), .NTAGS(NT), .RSP_DEPTH(DEP)) i_tagReqEngine (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIsStore(cmdIsStore),
    .cmdSize(cmdSize), .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdId(cmdId),
    .cmdReady(cmdReady), .flushReq(flushReq), .flushDone(flushDone),
    .usrRspValid(usrRspValid), .usrRspReady(usrRspReady),
    .usrRspData(usrRspData), .usrRspId(usrRspId), .protoErr(protoErr),
    .memLd(memLd), .memSt(memSt), .memSize(memSize), .memAddr(memAddr),
    .memWrdTag(memWrdTag), .memFlush(memFlush), .memRdStall(memRdStall),
    .memWrStall(memWrStall), .memRspPush(memRspPush), .memRspStall(memRspStall),
    .memRspData(memRspData), .memRspTag(memRspTag), .memFlushDone(memFlushDone)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lowFree();
    for (int i = 0; i < NT; i++) if (!bBusy[i]) return i;
    return -1;
  endfunction

  // Tasks start and end on a falling edge
  task automatic doLoad(input logic [47:0] a, input logic [1:0] sz, input logic [ID_W-1:0] id);
    int t;
    t = lowFree();
    cmdValid = 1; cmdIsStore = 0; cmdAddr = a; cmdSize = sz; cmdId = id;
    #1;
    chk(memLd && !memSt, "R2 load strobe", {memLd, memSt}, 2'b10);
    chk(memAddr == a, "R2 load addr", memAddr, a);
    chk(memSize == sz, "R3 load size", memSize, sz);
    chk(memWrdTag == 64'(t), "R5 load tag", memWrdTag, 64'(t));
    if (t >= 0) begin bBusy[t] = 1; bId[t] = id; end
    @(negedge clk); cmdValid = 0;
  endtask

  task automatic doStore(input logic [47:0] a, input logic [1:0] sz, input logic [63:0] d);
    cmdValid = 1; cmdIsStore = 1; cmdAddr = a; cmdSize = sz; cmdData = d;
    #1;
    chk(memSt && !memLd, "R2 store strobe", {memLd, memSt}, 2'b01);
    chk(memSize == sz, "R3 store size", memSize, sz);
    chk(memWrdTag == d, "R4 store data", memWrdTag, d);
    @(negedge clk); cmdValid = 0; cmdIsStore = 0;
  endtask

  task automatic memResp(input int t, input logic [63:0] d);
    memRspPush = 1; memRspTag = 32'(t); memRspData = d;
    #1;
    if (!memRspStall) begin expQ.push_back({bId[t], d}); pushedOk++; end
    bBusy[t] = 0;
    @(negedge clk); memRspPush = 0;
  endtask

  // Monitor: compare each delivered response with the scoreboard
  always @(negedge clk) begin
    if (rstN && usrRspValid && usrRspReady) begin
      delivered++;
      if (expQ.size() == 0) chk(0, "R7 unexpected response", {usrRspId, usrRspData}, 0);
      else begin
        logic [ID_W+63:0] e;
        e = expQ.pop_front();
        chk({usrRspId, usrRspData} == e, "R7 response id/data", {usrRspId, usrRspData}, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    chk({memLd, memSt, memFlush, flushDone, usrRspValid, memRspStall, protoErr} == 0,
        "R10 outputs idle", {memLd, memSt, memFlush, flushDone, usrRspValid, memRspStall, protoErr}, 0);
    chk(cmdReady == 1, "R10 load ready", cmdReady, 1);

    // Stores of different sizes
    doStore(48'h1234_5678_9ABC, 2'd3, 64'hDEAD_BEEF_0123_4567);
    doStore(48'h0000_0000_0011, 2'd0, 64'h0000_0000_0000_00A5);

    // R1: write stall blocks stores only
    memWrStall = 1;
    cmdValid = 1; cmdIsStore = 1; #1;
    chk(!cmdReady && !memSt, "R1 store held by write stall", {cmdReady, memSt}, 0);
    @(negedge clk); cmdValid = 0;
    doLoad(48'hAAAA_0000_0040, 2'd2, 8'h21);
    memWrStall = 0;
    // R1: read stall blocks loads only
    memRdStall = 1;
    cmdValid = 1; cmdIsStore = 0; #1;
    chk(!cmdReady && !memLd, "R1 load held by read stall", {cmdReady, memLd}, 0);
    @(negedge clk); cmdValid = 0;
    doStore(48'h55, 2'd1, 64'h0BAD_F00D);
    memRdStall = 0;
    memResp(0, 64'h1111);
    @(negedge clk);

    // R6: fill pool, then loads blocked, stores still ready
    doLoad(48'h100, 2'd3, 8'h30);
    doLoad(48'h108, 2'd3, 8'h31);
    doLoad(48'h110, 2'd3, 8'h32);
    doLoad(48'h118, 2'd3, 8'h33);
    cmdValid = 1; cmdIsStore = 0; #1;
    chk(!cmdReady && !memLd, "R6 load blocked when pool empty", {cmdReady, memLd}, 0);
    cmdIsStore = 1; #1;
    chk(cmdReady, "R6 store ready when pool empty", cmdReady, 1);
    @(negedge clk); cmdValid = 0; cmdIsStore = 0;
    // R7: out-of-order returns
    memResp(2, 64'h2222);
    memResp(0, 64'h3333);
    @(negedge clk);
    memResp(3, 64'h4444);
    memResp(1, 64'h5555);
    repeat (3) @(negedge clk);
    // R5/R6: freed tag 0 reused first
    doLoad(48'h200, 2'd1, 8'h40);
    memResp(0, 64'h6666);
    repeat (3) @(negedge clk);

    // R8: fill the buffer, then overflow
    usrRspReady = 0;
    for (int k = 0; k < 4; k++) doLoad(48'h300 + 48'(k), 2'd3, 8'h50 + 8'(k));
    memResp(3, 64'h7003);
    memResp(1, 64'h7001);
    memResp(0, 64'h7000);
    chk(!memRspStall, "R8 no stall below depth", memRspStall, 0);
    memResp(2, 64'h7002);
    chk(memRspStall, "R8 stall at depth", memRspStall, 1);
    chk(!protoErr, "R8 no error yet", protoErr, 0);
    doLoad(48'h400, 2'd0, 8'h60);
    memResp(0, 64'h7777);
    chk(protoErr, "R8 error on push while full", protoErr, 1);
    usrRspReady = 1;
    repeat (6) @(negedge clk);
    chk(!usrRspValid, "R8 dropped push not delivered", usrRspValid, 0);
    chk(protoErr, "R8 error sticky", protoErr, 1);

    // R9: flush after outstanding loads drain
    doLoad(48'h500, 2'd3, 8'h70);
    doLoad(48'h508, 2'd3, 8'h71);
    flushReq = 1; cmdValid = 1; cmdIsStore = 1; #1;
    chk(!cmdReady, "R9 blocked at flush accept", cmdReady, 0);
    @(negedge clk); flushReq = 0;
    cnt = 0;
    for (int k = 0; k < 4; k++) begin
      if (memFlush) cnt++;
      chk(!cmdReady, "R9 blocked while draining", cmdReady, 0);
      @(negedge clk);
    end
    chk(cnt == 0, "R9 no flush with loads outstanding", cnt, 0);
    cmdValid = 0; cmdIsStore = 0;
    memResp(1, 64'h8001);
    memResp(0, 64'h8000);
    for (int k = 0; k < 8; k++) begin
      if (memFlush) cnt++;
      @(negedge clk);
    end
    chk(cnt == 1, "R9 single flush pulse", cnt, 1);
    cmdIsStore = 1; #1;
    chk(!cmdReady && !flushDone, "R9 blocked awaiting complete", {cmdReady, flushDone}, 0);
    memFlushDone = 1; #1;
    chk(flushDone, "R9 flush done reported", flushDone, 1);
    @(negedge clk); memFlushDone = 0; #1;
    chk(cmdReady && !flushDone, "R9 commands resume", {cmdReady, flushDone}, 2'b10);
    cmdIsStore = 0;
    repeat (4) @(negedge clk);

    chk(expQ.size() == 0 && delivered == pushedOk, "R7 all responses delivered",
        delivered, pushedOk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule